// File: doc/BRIEF.md
# Clock-Stop Synchronous Serial Port (SPI Master/Slave)

The block is a full-duplex synchronous serial port that works as either an SPI master or an SPI slave in clock-stop operation. The serial clock only moves while a word is being exchanged and sits at a programmable idle level otherwise. The clock pin acts as SCK, the frame pin as the active-low slave select, one data pin carries transmitted bits and another carries received bits. Words go out most significant bit first.

Software places a word in a holding register. The port copies the word into its shift register when a transfer starts. In master mode that happens as soon as a word is waiting. In slave mode it happens when the external master pulls the select low. The received word is right-justified in a receive register with a ready flag. Static configuration inputs select the following:
- the clock scheme (a two-bit code plus a polarity bit);
- master or slave;
- the word length;
- the clock divider used in master mode.

Top module: `spi_cs_port`

## Requirements
- R1: After reset, tx_ready is 1, rx_ready is 0, rx_data is 0, ss_n_o is 1 and sck_o equals cfg_idle_high.
- R2: The port is enabled only when cfg_stop_mode[1] is 1. With codes 00 and 01 a written word is not sent: tx_ready stays 0, ss_n_o stays 1, sck_o stays idle, and sck_oe and ss_oe are 0.
- R3: cfg_len_code sets the word length N: 000=8, 001=12, 010=16, 011=20, 100=24, 101=32, and 110/111 are also 32. Bit N-1 of tx_data is sent first. The received word is right-justified in rx_data with zeros above bit N-1.
- R4: A tx_wr clears tx_ready. tx_ready sets again in the cycle the holding word is copied into the shift register. In master mode ss_n_o falls in that same cycle.
- R5: rx_ready sets once N bits have been sampled and rx_data then holds the word. rx_rd clears rx_ready, but a completing word in the same cycle wins.
- R6: Master timing, with H = cfg_div+1 clocks: ss_n_o is low for H clocks before the first SCK edge. SCK then makes exactly 2N transitions, H clocks apart. ss_n_o rises H clocks after the last transition and stays high for at least H clocks before the next word.
- R7: While no word is in progress, sck_o equals cfg_idle_high. A leading edge is a transition away from that level and a trailing edge is a transition back to it.
- R8: With cfg_stop_mode=10, data changes on leading edges and is sampled on trailing edges; the first bit appears when the word is loaded and is not shifted on the first leading edge. With cfg_stop_mode=11, data is shifted half a clock earlier: the first bit is present from the load, bits are sampled on leading edges and change on trailing edges.
- R9: In slave mode sck_oe and ss_oe are 0. A falling ss_n_i loads the holding word, and sck_i edges are decoded with the same scheme as in R8.
- R10: In slave mode, if ss_n_i rises before N bits have been sampled, the word is dropped and rx_ready does not set. The next select starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stop_mode | input | 2 | Clock-stop code; 1x enables, bit 0 selects early data |
| cfg_idle_high | input | 1 | Idle level of the serial clock |
| cfg_master | input | 1 | 1 = master (drives SCK and select), 0 = slave |
| cfg_len_code | input | 3 | Word length code |
| cfg_div | input | DIV_W | Master half-period minus one, in clocks |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 32 | Word to send, right-justified |
| tx_ready | output | 1 | Holding register free |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_data | output | 32 | Last received word |
| rx_ready | output | 1 | A new word is in rx_data |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_o | output | 1 | Active-low select out (master) |
| ss_oe | output | 1 | Select output enable |
| ss_n_i | input | 1 | Active-low select in (slave) |
| dx | output | 1 | Transmit data |
| dr | input | 1 | Receive data |

## Verification
The case that is hardest to reach from the ports is a slave word cut short: the select must rise in the middle of the word, after some samples have already been counted. Only a fresh word after that can show that the partial count was dropped. The bench acts as an external master and can stop toggling the clock after any number of edges. It aborts after five bits and then sends a full word, expecting exactly that word. In master mode the bench acts as an independent slave model. It watches every SCK transition, checks their spacing and drives its own word into dr. This covers all four clock schemes, all lengths and divider values from 1 upward under random choices, plus directed all-ones and alternating 32-bit words.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_LEAD,
        MS_RUN,
        MS_GAP
    } mst_state_e;

    // One cycle events that drive the shift engine
    typedef struct packed {
        logic load;
        logic lead;
        logic trail;
        logic abort;
    } edge_ev_t;

    function automatic logic [CNT_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(8);
            3'd1:    return CNT_W'(12);
            3'd2:    return CNT_W'(16);
            3'd3:    return CNT_W'(20);
            3'd4:    return CNT_W'(24);
            default: return CNT_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
    import spi_cs_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_ev_t      ev,
    input  logic [W-1:0]  hold_word,
    input  logic [CW-1:0] nbits,
    input  logic          early,
    input  logic          dr,
    output logic          dx,
    output logic          done,
    output logic [W-1:0]  rx_word
);

    localparam logic [CW-1:0] W_C = CW'(W);

    logic [W-1:0]  tx_sr;
    logic [CW-1:0] cnt;
    logic          first;
    logic          smp;
    logic          lau;

    always_comb begin
        smp = early ? ev.lead  : ev.trail;
        lau = early ? ev.trail : ev.lead;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_word <= '0;
            cnt     <= '0;
            first   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ev.load) begin
                tx_sr   <= hold_word << (W_C - nbits);
                rx_word <= '0;
                cnt     <= '0;
                first   <= 1'b1;
            end else begin
                if (ev.abort) begin
                    cnt <= '0;
                end else if (smp && cnt != nbits) begin
                    rx_word <= {rx_word[W-2:0], dr};
                    cnt     <= cnt + CW'(1);
                    if (cnt + CW'(1) == nbits)
                        done <= 1'b1;
                end
                if (lau) begin
                    if (!early && first)
                        first <= 1'b0;
                    else
                        tx_sr <= tx_sr << 1;
                end
            end
        end
    end

    assign dx = tx_sr[W-1];

    // R8: transmit data only moves on a launch edge or a load
    a_r8_dx_moves_on_launch_only: assert property (@(posedge clk) disable iff (rst)
        (!lau && !ev.load) |=> $stable(dx));

endmodule

// File: rtl/spi_cs_master_gen.sv
module spi_cs_master_gen
    import spi_cs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    input  logic [CW-1:0]    nbits,
    output edge_ev_t         ev,
    output logic             ss_n,
    output logic             ph
);

    mst_state_e       st;
    logic [DIV_W-1:0] hcnt;
    logic [CW:0]      ecnt;
    logic             tick;
    logic             last_edge;

    assign tick      = (hcnt == div);
    assign last_edge = (ecnt == {nbits, 1'b0});

    always_comb begin
        ev       = '0;
        ev.load  = (st == MS_IDLE) && go;
        ev.lead  = tick && ((st == MS_LEAD) ||
                            (st == MS_RUN && !last_edge && !ecnt[0]));
        ev.trail = tick && (st == MS_RUN) && !last_edge && ecnt[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MS_IDLE;
            hcnt <= '0;
            ecnt <= '0;
            ss_n <= 1'b1;
            ph   <= 1'b0;
        end else begin
            if (st == MS_IDLE || tick)
                hcnt <= '0;
            else
                hcnt <= hcnt + DIV_W'(1);
            case (st)
                MS_IDLE: if (go) begin
                    st   <= MS_LEAD;
                    ss_n <= 1'b0;
                    ecnt <= '0;
                end
                MS_LEAD: if (tick) begin
                    st   <= MS_RUN;
                    ph   <= ~ph;
                    ecnt <= {{CW{1'b0}}, 1'b1};
                end
                MS_RUN: if (tick) begin
                    if (last_edge) begin
                        st   <= MS_GAP;
                        ss_n <= 1'b1;
                    end else begin
                        ph   <= ~ph;
                        ecnt <= ecnt + {{CW{1'b0}}, 1'b1};
                    end
                end
                MS_GAP: if (tick) st <= MS_IDLE;
                default: st <= MS_IDLE;
            endcase
        end
    end

    // R6: the clock phase only changes on a divider tick
    a_r6_phase_steady_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ph));

    // R7: the clock is back home when the select is released
    a_r7_phase_home_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> !ph);

endmodule

// File: rtl/spi_cs_slave_front.sv
module spi_cs_slave_front
    import spi_cs_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     idle_hi,
    input  logic     sck_i,
    input  logic     ss_n_i,
    output edge_ev_t ev
);

    logic [SYNC-1:0] sck_s;
    logic [SYNC-1:0] ss_s;
    logic            sck_d;
    logic            ss_d;
    logic            sck_now;
    logic            ss_now;
    logic            chg;

    assign sck_now = sck_s[SYNC-1];
    assign ss_now  = ss_s[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s <= {SYNC{idle_hi}};
            ss_s  <= '1;
            sck_d <= idle_hi;
            ss_d  <= 1'b1;
        end else begin
            sck_s <= {sck_s[SYNC-2:0], sck_i};
            ss_s  <= {ss_s[SYNC-2:0], ss_n_i};
            sck_d <= sck_now;
            ss_d  <= ss_now;
        end
    end

    always_comb begin
        ev       = '0;
        ev.load  = active && ss_d && !ss_now;
        ev.abort = active && !ss_d && ss_now;
        chg      = active && !ss_now && !ss_d && (sck_now != sck_d);
        ev.lead  = chg && (sck_now != idle_hi);
        ev.trail = chg && (sck_now == idle_hi);
    end

endmodule

// File: rtl/spi_cs_port.sv
module spi_cs_port
    import spi_cs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_stop_mode,
    input  logic              cfg_idle_high,
    input  logic              cfg_master,
    input  logic [2:0]        cfg_len_code,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              ss_n_o,
    output logic              ss_oe,
    input  logic              ss_n_i,
    output logic              dx,
    input  logic              dr
);

    logic              en;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] rx_word;
    logic              eng_done;
    logic              m_ph;
    edge_ev_t          m_ev;
    edge_ev_t          s_ev;
    edge_ev_t          ev;

    assign en     = cfg_stop_mode[1];
    assign nbits  = word_bits(cfg_len_code);
    assign ev     = cfg_master ? m_ev : s_ev;
    assign sck_o  = m_ph ^ cfg_idle_high;
    assign sck_oe = en && cfg_master;
    assign ss_oe  = en && cfg_master;

    spi_cs_master_gen #(.DIV_W(DIV_W), .CW(CNT_W)) u_mst (
        .clk   (clk),
        .rst   (rst),
        .go    (en && cfg_master && !tx_ready),
        .div   (cfg_div),
        .nbits (nbits),
        .ev    (m_ev),
        .ss_n  (ss_n_o),
        .ph    (m_ph)
    );

    spi_cs_slave_front #(.SYNC(SYNC)) u_slv (
        .clk     (clk),
        .rst     (rst),
        .active  (en && !cfg_master),
        .idle_hi (cfg_idle_high),
        .sck_i   (sck_i),
        .ss_n_i  (ss_n_i),
        .ev      (s_ev)
    );

    spi_cs_engine #(.W(WORD_W), .CW(CNT_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .hold_word (hold_q),
        .nbits     (nbits),
        .early     (cfg_stop_mode[0]),
        .dr        (dr),
        .dx        (dx),
        .done      (eng_done),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            tx_ready <= 1'b1;
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else begin
            if (tx_wr) begin
                hold_q   <= tx_data;
                tx_ready <= 1'b0;
            end else if (ev.load) begin
                tx_ready <= 1'b1;
            end
            if (eng_done) begin
                rx_data  <= rx_word;
                rx_ready <= 1'b1;
            end else if (rx_rd) begin
                rx_ready <= 1'b0;
            end
        end
    end

    // R4
    a_r4_load_sets_tx_ready: assert property (@(posedge clk) disable iff (rst)
        (ev.load && !tx_wr) |=> tx_ready);
    a_r4_write_clears_tx_ready: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !tx_ready);
    // R5
    a_r5_done_sets_rx_ready: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> rx_ready);
    a_r5_read_clears_rx_ready: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !eng_done) |=> !rx_ready);
    // R2
    a_r2_holding_waits_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !tx_wr) |=> $stable(tx_ready));
    // R7
    a_r7_idle_level_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && ss_n_o) |-> (sck_o == cfg_idle_high));

endmodule

// File: tb/spi_cs_port_bench.sv
module spi_cs_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_stop_mode = 2'b10;
    logic        cfg_idle_high = 1'b0;
    logic        cfg_master = 1'b1;
    logic [2:0]  cfg_len_code = 3'd0;
    logic [7:0]  cfg_div = 8'd1;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_data;
    logic        rx_ready;
    logic        sck_o, sck_oe, ss_n_o, ss_oe, dx;
    logic        sck_s = 1'b0;
    logic        ss_s = 1'b1;
    logic        dr_m = 1'b0;
    logic        dr_s = 1'b0;
    logic        dr;

    assign dr = cfg_master ? dr_m : dr_s;

    always #10 clk = ~clk;

    spi_cs_port u_spi_cs_port (
        .clk(clk), .rst(rst), .cfg_stop_mode(cfg_stop_mode), .cfg_idle_high(cfg_idle_high),
        .cfg_master(cfg_master), .cfg_len_code(cfg_len_code), .cfg_div(cfg_div),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_s), .ss_n_o(ss_n_o), .ss_oe(ss_oe), .ss_n_i(ss_s), .dx(dx), .dr(dr)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [63:0] msk(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    // slave model used while the design is master
    logic [31:0] m_word = '0;
    int          m_n = 8;
    bit          m_early = 1'b0;
    int          m_h = 1;
    int          idx = 0;
    int          edges = 0;
    int          last = 0;
    int          tm_err = 0;
    int          idle_err = 0;
    logic [63:0] cap = '0;
    logic        prev_sck = 1'b0;
    logic        prev_ss = 1'b1;
    bit          lead;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (cfg_master && !rst) begin
            if (prev_ss && !ss_n_o) begin
                idx = m_n - 1; cap = '0; edges = 0; last = cyc;
                if (m_early) dr_m = m_word[idx];
                if (sck_o != cfg_idle_high) idle_err++;
            end else if (!prev_ss && ss_n_o) begin
                if (cyc - last != m_h) tm_err++;
            end
            if (sck_o != prev_sck && !ss_n_o) begin
                if (cyc - last != m_h) tm_err++;
                last = cyc; edges++;
                lead = (sck_o != cfg_idle_high);
                if (lead == m_early) begin
                    cap = {cap[62:0], dx};
                end else if (lead) begin
                    if (idx >= 0) dr_m = m_word[idx];
                    idx--;
                end else begin
                    idx--;
                    if (idx >= 0) dr_m = m_word[idx];
                end
            end
            if (ss_n_o && sck_o != cfg_idle_high) idle_err++;
        end
        prev_sck = sck_o;
        prev_ss  = ss_n_o;
    end

    task automatic wait_for(input bit which);
        for (int i = 0; i < 6000; i++) begin
            if (which ? rx_ready : ss_n_o) break;
            @(negedge clk);
        end
    endtask

    task automatic run_master(input logic [1:0] code, input bit idle, input logic [2:0] lc,
                              input logic [7:0] div, input logic [31:0] txw,
                              input logic [31:0] sw, input bit do_write);
        int n;
        int te0;
        int ie0;
        n = nb(lc);
        te0 = tm_err; ie0 = idle_err;
        @(negedge clk);
        cfg_master = 1'b1; cfg_idle_high = idle; cfg_len_code = lc; cfg_div = div;
        m_word = sw; m_n = n; m_early = code[0]; m_h = int'(div) + 1;
        cfg_stop_mode = code;
        if (do_write) begin
            tx_wr = 1'b1; tx_data = txw;
            @(negedge clk);
            tx_wr = 1'b0;
            chk(tx_ready == 1'b0, "R4 write clears tx_ready", 64'(tx_ready), 64'd0);
            @(negedge clk);
            chk(tx_ready == 1'b1 && ss_n_o == 1'b0, "R4 load sets tx_ready with select low",
                {tx_ready, ss_n_o}, 64'b10);
        end
        @(negedge clk);
        wait_for(1'b1);
        wait_for(1'b0);
        chk(rx_data == 32'(64'(sw) & msk(n)), "R5 R8 master received word", 64'(rx_data), 64'(sw) & msk(n));
        chk(cap == (64'(txw) & msk(n)), "R3 R8 master sent word", cap, 64'(txw) & msk(n));
        chk(edges == 2 * n, "R6 edge count", 64'(edges), 64'(2 * n));
        chk(tm_err == te0, "R6 edge spacing", 64'(tm_err - te0), 64'd0);
        chk(idle_err == ie0, "R7 idle level", 64'(idle_err - ie0), 64'd0);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_ready == 1'b0, "R5 read clears rx_ready", 64'(rx_ready), 64'd0);
        repeat (2 * int'(div) + 4) @(negedge clk);
    endtask

    task automatic run_slave(input logic [1:0] code, input bit idle, input logic [2:0] lc,
                             input logic [31:0] txw, input logic [31:0] mw, input int nedge);
        int n;
        int j;
        logic [63:0] sc;
        bit ld;
        n = nb(lc); j = n - 1; sc = '0;
        @(negedge clk);
        cfg_master = 1'b0; cfg_idle_high = idle; cfg_len_code = lc; cfg_stop_mode = code;
        sck_s = idle; ss_s = 1'b1;
        repeat (6) @(negedge clk);
        chk(sck_oe == 1'b0 && ss_oe == 1'b0, "R9 slave outputs off", {sck_oe, ss_oe}, 64'd0);
        tx_wr = 1'b1; tx_data = txw;
        @(negedge clk);
        tx_wr = 1'b0;
        ss_s = 1'b0;
        if (code[0]) dr_s = mw[j];
        repeat (6) @(negedge clk);
        chk(tx_ready == 1'b1, "R9 select loads holding word", 64'(tx_ready), 64'd1);
        for (int e = 0; e < nedge; e++) begin
            ld = (e % 2 == 0);
            if (ld == code[0]) begin
                sc = {sc[62:0], dx};
            end else if (ld) begin
                if (j >= 0) dr_s = mw[j];
                j--;
            end else begin
                j--;
                if (j >= 0) dr_s = mw[j];
            end
            sck_s = ~sck_s;
            repeat (6) @(negedge clk);
        end
        ss_s = 1'b1;
        repeat (8) @(negedge clk);
        if (nedge < 2 * n) begin
            chk(rx_ready == 1'b0, "R10 aborted word dropped", 64'(rx_ready), 64'd0);
        end else begin
            chk(rx_ready == 1'b1, "R9 slave rx_ready", 64'(rx_ready), 64'd1);
            chk(rx_data == 32'(64'(mw) & msk(n)), "R9 R8 slave received word", 64'(rx_data), 64'(mw) & msk(n));
            chk(sc == (64'(txw) & msk(n)), "R9 R8 slave sent word", sc, 64'(txw) & msk(n));
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b1 && rx_ready == 1'b0 && rx_data == '0, "R1 flags after reset",
            {tx_ready, rx_ready, rx_data}, {1'b1, 1'b0, 32'd0});
        chk(ss_n_o == 1'b1 && sck_o == cfg_idle_high, "R1 pins after reset", {ss_n_o, sck_o}, 64'b10);

        // four clock schemes, directed
        run_master(2'b10, 1'b0, 3'd0, 8'd1, 32'h0000_00A5, 32'h0000_003C, 1'b1);
        run_master(2'b10, 1'b1, 3'd0, 8'd2, 32'h0000_0081, 32'h0000_00F0, 1'b1);
        run_master(2'b11, 1'b0, 3'd1, 8'd0, 32'h0000_0ABC, 32'h0000_0555, 1'b1);
        run_master(2'b11, 1'b1, 3'd2, 8'd3, 32'h0000_8001, 32'h0000_7FFE, 1'b1);
        // R3 longest words and the aliased codes
        run_master(2'b10, 1'b0, 3'd5, 8'd0, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 1'b1);
        run_master(2'b11, 1'b1, 3'd7, 8'd1, 32'h5555_5555, 32'h8000_0001, 1'b1);
        run_master(2'b10, 1'b1, 3'd6, 8'd0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
        // R3 upper bits beyond N are ignored
        run_master(2'b11, 1'b0, 3'd0, 8'd1, 32'hFFFF_FF5A, 32'hFFFF_FFC3, 1'b1);

        // R2 disabled codes hold the word back
        @(negedge clk);
        cfg_master = 1'b1; cfg_stop_mode = 2'b01; cfg_len_code = 3'd0; cfg_idle_high = 1'b1;
        tx_wr = 1'b1; tx_data = 32'h0000_0096;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (40) @(negedge clk);
        chk(tx_ready == 1'b0 && ss_n_o == 1'b1, "R2 no transfer when disabled", {tx_ready, ss_n_o}, 64'b01);
        chk(sck_o == 1'b1 && sck_oe == 1'b0 && ss_oe == 1'b0, "R2 pins idle when disabled",
            {sck_o, sck_oe, ss_oe}, 64'b100);
        cfg_stop_mode = 2'b00;
        repeat (10) @(negedge clk);
        chk(tx_ready == 1'b0 && ss_n_o == 1'b1, "R2 code 00 also disabled", {tx_ready, ss_n_o}, 64'b01);
        run_master(2'b10, 1'b1, 3'd0, 8'd1, 32'h0000_0096, 32'h0000_0069, 1'b0);

        // random master words
        for (int k = 0; k < 12; k++) begin
            logic [1:0] c;
            logic [2:0] l;
            c = {1'b1, 1'($urandom)};
            l = 3'($urandom % 6);
            run_master(c, 1'($urandom), l, 8'($urandom % 4), $urandom, $urandom, 1'b1);
        end

        // slave mode
        run_slave(2'b10, 1'b0, 3'd0, 32'h0000_00C3, 32'h0000_005A, 16);
        run_slave(2'b11, 1'b1, 3'd1, 32'h0000_0F0F, 32'h0000_0A5A, 24);
        run_slave(2'b11, 1'b0, 3'd0, 32'h0000_00FF, 32'h0000_0081, 10);
        run_slave(2'b11, 1'b0, 3'd0, 32'h0000_0033, 32'h0000_00E7, 16);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] c;
            logic [2:0] l;
            c = {1'b1, 1'($urandom)};
            l = 3'($urandom % 6);
            run_slave(c, 1'($urandom), l, $urandom, $urandom, 2 * nb(l));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule